// File: doc/BRIEF.md
# Alert Classification and Interrupt Unit

This block sits behind a set of alert receivers. Each receiver raises a one-cycle pulse when an alert handshake from its source has finished, together with a flag that says whether that handshake timed out. The unit filters the pulses through per-alert enable bits. It records every accepted alert in a sticky cause register. It also sorts each accepted alert into one of four classes, using a two-bit field per alert held in a class-map register.

Each class owns a sticky state bit and one interrupt line. The line is raised when the class state bit and the class interrupt-enable bit are both set. With the enable clear, software can still find the event by polling the state register.

All configuration and status registers sit behind a simple single-cycle register port with a word address. The write-data port takes writes. Reads return data combinationally for the address that is presented. The cause and state registers are write-one-to-clear.

Top module: `alert_class_irq`

## Requirements
- R1: After a synchronous active-low reset, the registers read back as follows. Alert enable (word 0) is all ones. Class map (word 1), cause (word 2), class state (word 3) and interrupt enable (word 4) are zero. Every interrupt output is low.
- R2: A pulse on an alert whose enable bit (word 0, bit i) is clear changes neither the cause register nor the class state.
- R3: A pulse whose timeout flag is set in the same cycle is ignored completely.
- R4: An accepted pulse on alert i sets cause bit i on the next clock edge.
- R5: An accepted pulse on alert i sets the state bit of the class given by class-map bits [2i+1:2i], on the next clock edge. Class A is value 0 and state bit 0; class D is value 3 and state bit 3.
- R6: While the class map holds its reset value, every accepted alert sets state bit 0 (class A).
- R7: When alerts arrive in the same cycle, every one of them is recorded, each in its own cause bit and in its own class state bit.
- R8: Writing a 1 to a bit of the cause register or the state register clears that bit. Bits written with 0 keep their value.
- R9: If a set event and a write-one-to-clear hit the same cause or state bit in the same cycle, the bit ends up set.
- R10: Interrupt output c is registered. It equals (state bit c AND interrupt-enable bit c) as they stood one cycle earlier. A state bit is still set while its interrupt-enable bit is clear.
- R11: Words 0, 1 and 4 read back what was written to them, limited to their implemented widths. Addresses 5 to 7 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alert_pulse_i | input | N_ALERTS | One-cycle pulse per alert: the handshake for that alert has finished |
| alert_timeout_i | input | N_ALERTS | Set together with the pulse when that alert's handshake timed out |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| irq_o | output | 4 | One interrupt line per class, A in bit 0 to D in bit 3 |

## Verification
The bench goes after five corner cases.

Disabled alerts and timed-out alerts are driven alongside accepted ones. A design that gated only one of the two would show stray cause or state bits.

All alerts are fired in one cycle under a map that sends them to different classes. A design that kept only one winner per cycle, or that decoded the two-bit field at the wrong position, would set the wrong class bits.

A clear is written in the same cycle as a new event on the same bit. A design with clear priority would lose that event.

The interrupt lines are compared on every clock against a behavioural model. This catches a combinational or two-stage output, and also a state bit that stops being set while its interrupt is disabled.

// File: rtl/acu_pkg.sv
// Package: shared constants and the register address map of the alert
// classification unit. Assumes a 32-bit register port with word addresses.
package acu_pkg;
    localparam int DW        = 32;
    localparam int AW        = 3;
    localparam int N_CLASSES = 4;
    localparam int CLS_W     = 2;

    typedef enum logic [AW-1:0] {
        ADDR_ALERT_EN  = 3'd0,
        ADDR_CLASS_MAP = 3'd1,
        ADDR_CAUSE     = 3'd2,
        ADDR_IRQ_STATE = 3'd3,
        ADDR_IRQ_EN    = 3'd4
    } acu_addr_e;
endpackage

// File: rtl/acu_classify.sv
// Module: combinational gating and class decode of alert pulses.
// A pulse is accepted when its alert is enabled and its handshake did not
// time out. Each accepted pulse is routed to one class through its 2-bit field.
// Assumes that map_i packs the field for alert i at bits [2i+1:2i].
module acu_classify
    import acu_pkg::*;
#(
    parameter int N_ALERTS = 6
) (
    input  logic [N_ALERTS-1:0]       pulse_i,
    input  logic [N_ALERTS-1:0]       timeout_i,
    input  logic [N_ALERTS-1:0]       enable_i,
    input  logic [CLS_W*N_ALERTS-1:0] map_i,
    output logic [N_ALERTS-1:0]       accept_o,
    output logic [N_CLASSES-1:0]      class_set_o
);
    // accept filter: valid handshake and enabled source
    assign accept_o = pulse_i & ~timeout_i & enable_i;

    // one OR-reduction per class over the alerts mapped to it
    for (genvar c = 0; c < N_CLASSES; c++) begin : g_class
        always_comb begin
            class_set_o[c] = 1'b0;
            for (int i = 0; i < N_ALERTS; i++) begin
                if (accept_o[i] && (map_i[CLS_W*i +: CLS_W] == CLS_W'(c))) begin
                    class_set_o[c] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/acu_sticky.sv
// Module: a vector of sticky bits with write-one-to-clear.
// When set and clear hit the same bit in the same cycle, set wins.
// Assumes synchronous active-low reset to zero.
module acu_sticky #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    // update: clear the requested bits, then OR in the new events
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= (q_o & ~clr_i) | set_i;
    end

    // set events are never lost, even under a concurrent clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

    // with no event and no clear, the bits hold
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/acu_cfg_regs.sv
// Module: the configuration registers of the unit (alert enables, class map
// and per-class interrupt enables). Assumes the write data arrives already
// sliced to each register's width.
module acu_cfg_regs
    import acu_pkg::*;
#(
    parameter int N_ALERTS = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_en_i,
    input  logic                      we_map_i,
    input  logic                      we_ien_i,
    input  logic [N_ALERTS-1:0]       wdata_en_i,
    input  logic [CLS_W*N_ALERTS-1:0] wdata_map_i,
    input  logic [N_CLASSES-1:0]      wdata_ien_i,
    output logic [N_ALERTS-1:0]       alert_en_o,
    output logic [CLS_W*N_ALERTS-1:0] class_map_o,
    output logic [N_CLASSES-1:0]      irq_en_o
);
    // alert enables: reset to all ones
    always_ff @(posedge clk) begin
        if (!rst_n)       alert_en_o <= '1;
        else if (we_en_i) alert_en_o <= wdata_en_i;
    end

    // class map: reset to zero, so every alert routes to class A
    always_ff @(posedge clk) begin
        if (!rst_n)        class_map_o <= '0;
        else if (we_map_i) class_map_o <= wdata_map_i;
    end

    // per-class interrupt enables: reset to zero
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_en_o <= '0;
        else if (we_ien_i) irq_en_o <= wdata_ien_i;
    end

    // enables only change through a write
    assert_en_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !we_en_i |=> $stable(alert_en_o));
endmodule

// File: rtl/alert_class_irq.sv
// Module: top of the alert classification and interrupt unit.
// It gates alert pulses, logs them in a sticky cause register and sets the
// per-class state. It drives registered interrupts and serves a single-cycle
// register port. Assumes N_ALERTS <= 16, so that the class map fits one word.
module alert_class_irq
    import acu_pkg::*;
#(
    parameter int N_ALERTS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_ALERTS-1:0] alert_pulse_i,
    input  logic [N_ALERTS-1:0] alert_timeout_i,
    input  logic                reg_we_i,
    input  logic [AW-1:0]       reg_addr_i,
    input  logic [DW-1:0]       reg_wdata_i,
    output logic [DW-1:0]       reg_rdata_o,
    output logic [N_CLASSES-1:0] irq_o
);
    localparam int MAP_W = CLS_W * N_ALERTS;

    logic [N_ALERTS-1:0]  alert_en_q;
    logic [MAP_W-1:0]     class_map_q;
    logic [N_CLASSES-1:0] irq_en_q;
    logic [N_ALERTS-1:0]  accept;
    logic [N_CLASSES-1:0] class_set;
    logic [N_ALERTS-1:0]  cause_q;
    logic [N_CLASSES-1:0] state_q;
    logic [N_ALERTS-1:0]  cause_clr;
    logic [N_CLASSES-1:0] state_clr;
    logic                 we_en, we_map, we_ien, we_cause, we_state;
    logic                 unused_wdata;

    // address decode of the write strobe
    assign we_en    = reg_we_i && (reg_addr_i == ADDR_ALERT_EN);
    assign we_map   = reg_we_i && (reg_addr_i == ADDR_CLASS_MAP);
    assign we_ien   = reg_we_i && (reg_addr_i == ADDR_IRQ_EN);
    assign we_cause = reg_we_i && (reg_addr_i == ADDR_CAUSE);
    assign we_state = reg_we_i && (reg_addr_i == ADDR_IRQ_STATE);
    assign unused_wdata = ^reg_wdata_i;

    // write-one-to-clear masks
    assign cause_clr = we_cause ? reg_wdata_i[N_ALERTS-1:0]  : '0;
    assign state_clr = we_state ? reg_wdata_i[N_CLASSES-1:0] : '0;

    acu_cfg_regs #(.N_ALERTS(N_ALERTS)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_en_i     (we_en),
        .we_map_i    (we_map),
        .we_ien_i    (we_ien),
        .wdata_en_i  (reg_wdata_i[N_ALERTS-1:0]),
        .wdata_map_i (reg_wdata_i[MAP_W-1:0]),
        .wdata_ien_i (reg_wdata_i[N_CLASSES-1:0]),
        .alert_en_o  (alert_en_q),
        .class_map_o (class_map_q),
        .irq_en_o    (irq_en_q)
    );

    acu_classify #(.N_ALERTS(N_ALERTS)) u_classify (
        .pulse_i     (alert_pulse_i),
        .timeout_i   (alert_timeout_i),
        .enable_i    (alert_en_q),
        .map_i       (class_map_q),
        .accept_o    (accept),
        .class_set_o (class_set)
    );

    acu_sticky #(.W(N_ALERTS)) u_cause (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (accept),
        .clr_i (cause_clr),
        .q_o   (cause_q)
    );

    acu_sticky #(.W(N_CLASSES)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (class_set),
        .clr_i (state_clr),
        .q_o   (state_q)
    );

    // registered interrupt lines: state gated by enable
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= '0;
        else        irq_o <= state_q & irq_en_q;
    end

    // read mux: zero-extended register contents, unmapped words read zero
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_ALERT_EN:  reg_rdata_o[N_ALERTS-1:0]  = alert_en_q;
            ADDR_CLASS_MAP: reg_rdata_o[MAP_W-1:0]     = class_map_q;
            ADDR_CAUSE:     reg_rdata_o[N_ALERTS-1:0]  = cause_q;
            ADDR_IRQ_STATE: reg_rdata_o[N_CLASSES-1:0] = state_q;
            ADDR_IRQ_EN:    reg_rdata_o[N_CLASSES-1:0] = irq_en_q;
            default:        reg_rdata_o = '0;
        endcase
    end

    // a new cause bit needs an enabled alert in the previous cycle
    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((cause_q & ~$past(cause_q) & ~$past(alert_en_q)) == '0));

    // a new cause bit needs a pulse without timeout in the previous cycle
    assert_timeout_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((cause_q & ~$past(cause_q) &
                   ~($past(alert_pulse_i) & ~$past(alert_timeout_i))) == '0));

    // an interrupt line is only high if its state bit was set a cycle before
    assert_irq_needs_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((irq_o & ~$past(state_q)) == '0));

    // an interrupt line is only high if its enable was set a cycle before
    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((irq_o & ~$past(irq_en_q)) == '0));
endmodule

// File: tb/alert_class_irq_bench.sv
// Bench: drives the unit from tasks at the falling edge and keeps a
// behavioural model of every register. It compares the interrupt lines each
// cycle and the read data of the addressed register.
module alert_class_irq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NA-1:0] pulse = '0;
    logic [NA-1:0] tmo = '0;
    logic          we = 1'b0;
    logic [2:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [3:0]    irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // model state
    bit [NA-1:0]   m_en = '1;
    bit [2*NA-1:0] m_map = '0;
    bit [NA-1:0]   m_cause = '0;
    bit [3:0]      m_state = '0;
    bit [3:0]      m_ien = '0;
    bit [3:0]      m_irq = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alert_class_irq #(.N_ALERTS(NA)) u_alert_class_irq (
        .clk             (clk),
        .rst_n           (rst_n),
        .alert_pulse_i   (pulse),
        .alert_timeout_i (tmo),
        .reg_we_i        (we),
        .reg_addr_i      (addr),
        .reg_wdata_i     (wdata),
        .reg_rdata_o     (rdata),
        .irq_o           (irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit [31:0] model_read(bit [2:0] a);
        case (a)
            3'd0: return 32'(m_en);
            3'd1: return 32'(m_map);
            3'd2: return 32'(m_cause);
            3'd3: return 32'(m_state);
            3'd4: return 32'(m_ien);
            default: return 32'd0;
        endcase
    endfunction

    // one cycle: drive at the falling edge, check, advance the model at the rising edge
    task automatic cyc(string req, bit [NA-1:0] p, bit [NA-1:0] t,
                       bit w, bit [2:0] a, bit [31:0] d);
        bit [NA-1:0] acc;
        bit [3:0]    cset;
        bit [NA-1:0] cclr;
        bit [3:0]    sclr;
        pulse = p; tmo = t; we = w; addr = a; wdata = d;
        #1;
        chk({req, " irq (R10)"}, 32'(irq), 32'(m_irq));
        chk({req, " rdata"}, rdata, model_read(a));
        @(posedge clk);
        acc  = p & ~t & m_en;
        cset = '0;
        for (int i = 0; i < NA; i++)
            if (acc[i]) cset[m_map[2*i +: 2]] = 1'b1;
        cclr = (w && a == 3'd2) ? d[NA-1:0] : '0;
        sclr = (w && a == 3'd3) ? d[3:0] : '0;
        m_irq   = m_state & m_ien;
        m_cause = (m_cause & ~cclr) | acc;
        m_state = (m_state & ~sclr) | cset;
        if (w && a == 3'd0) m_en  = d[NA-1:0];
        if (w && a == 3'd1) m_map = d[2*NA-1:0];
        if (w && a == 3'd4) m_ien = d[3:0];
        @(negedge clk);
    endtask

    task automatic rd(string req, bit [2:0] a);
        cyc(req, '0, '0, 1'b0, a, '0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        for (int a = 0; a < 8; a++) rd("R1 reset", 3'(a));
        // R4 R6 alert 0 with default map -> class A, interrupt disabled (R10 polling)
        cyc("R4 R6", 6'b000001, '0, 1'b0, 3'd2, '0);
        rd("R4 cause", 3'd2);
        rd("R6 state", 3'd3);
        // R10 enable interrupts: irq rises one cycle after
        cyc("R11 ien", '0, '0, 1'b1, 3'd4, 32'hF);
        rd("R10 irq", 3'd4);
        rd("R10 irq", 3'd3);
        // R8 clear state and cause
        cyc("R8 state", '0, '0, 1'b1, 3'd3, 32'h1);
        cyc("R8 cause", '0, '0, 1'b1, 3'd2, 32'h1);
        rd("R8 cause", 3'd2);
        rd("R8 state", 3'd3);
        // R2 disable alert 2 and pulse it
        cyc("R11 en", '0, '0, 1'b1, 3'd0, 32'h3B);
        rd("R11 en", 3'd0);
        cyc("R2", 6'b000100, '0, 1'b0, 3'd2, '0);
        rd("R2 cause", 3'd2);
        rd("R2 state", 3'd3);
        // R3 timed-out handshake
        cyc("R3", 6'b000010, 6'b000010, 1'b0, 3'd2, '0);
        rd("R3 cause", 3'd2);
        rd("R3 state", 3'd3);
        // R5 map: a0->D a1->C a2->B a3->A a4->D a5->B
        cyc("R11 map", '0, '0, 1'b1, 3'd1, 32'h71B);
        rd("R11 map", 3'd1);
        cyc("R5", 6'b000010, '0, 1'b0, 3'd3, '0);
        rd("R5 state", 3'd3);
        cyc("R8", '0, '0, 1'b1, 3'd3, 32'hF);
        cyc("R8", '0, '0, 1'b1, 3'd2, 32'h3F);
        cyc("R11 en", '0, '0, 1'b1, 3'd0, 32'h3F);
        // R7 all alerts at once
        cyc("R7", 6'b111111, '0, 1'b0, 3'd2, '0);
        rd("R7 cause", 3'd2);
        rd("R7 state", 3'd3);
        // R9 set and clear on the same bit in the same cycle
        cyc("R9 cause", 6'b010000, '0, 1'b1, 3'd2, 32'h3F);
        rd("R9 cause", 3'd2);
        cyc("R9 state", 6'b001000, '0, 1'b1, 3'd3, 32'hF);
        rd("R9 state", 3'd3);
        // R11 unmapped address
        cyc("R11 bad", '0, '0, 1'b1, 3'd7, 32'hFFFF_FFFF);
        for (int a = 0; a < 8; a++) rd("R11 after bad write", 3'(a));
        // mixed random traffic against the model
        for (int n = 0; n < 400; n++) begin
            bit w;
            w = ($urandom_range(0, 3) == 0);
            cyc("R5 R7 R9 random", NA'($urandom), NA'($urandom_range(0, 3) == 0 ? $urandom : 0),
                w, 3'($urandom_range(0, 5)), $urandom);
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule